// File: doc/BRIEF.md
# PHY Management Register Bank

This block models the management register set of a 10/100 Ethernet PHY as seen from a host. It holds sixteen 16-bit registers that a register index selects. The host reads and writes them through a single-cycle strobe interface. A read strobe returns the selected register on the following cycle. A write strobe stores, ignores or acts on the write data, depending on the register it targets. A control register write with its top bit set starts a soft reset of the whole bank, and the written value is not kept.

The block has a level input that carries the current link state. Each time that level changes, the block updates the link bit in the status register and the ability bits in the link-partner register. After any reset, hard or soft, the block applies the link state that is present at that moment.

The serial management wire protocol is not part of this block. A serial front end would sit in front of the strobe interface.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset these values read back: index 0 (control) = 0x1000, index 1 (status) = 0x7848 with bit 2 equal to the link input, index 2 = 0x2000, index 3 = 0x5C90, index 4 (advertisement) = 0x01E1, index 5 (partner ability) = 0x01E1 if the link is up and 0x0000 if it is down, every other index = 0x0000. rd_data is 0x0000 while reset is held.
- R2: When rd_en is sampled high, rd_data carries the selected register after that clock edge. rd_data holds its value in every cycle without a read. A read and a write to the same index in the same cycle return the value from before the write.
- R3: A write to any index from 4 to 15 stores wr_data unchanged.
- R4: Writes to indices 1, 2 and 3 change nothing.
- R5: A write to index 0 with wr_data bit 15 clear stores the value. A write with bit 15 set reloads the whole bank to the R1 values, using the current link level, and does not store the written value.
- R6: On the first clock edge where the link input is sampled high after being low, status bit 2 is set and 0x01E1 is ORed into index 5.
- R7: On the first clock edge where the link input is sampled low after being high, status bit 2 is cleared and index 5 is ANDed with 0x01FF.
- R8: A write to index 5 in the same cycle as a link change stores wr_data, and then the R6/R7 rule is applied to it. A write to another writable index in that cycle is stored unaffected.
- R9: Only the 16 indices below 16 exist. A write with reg_idx of 16 or more changes no register, including the register with the same low four bits. A read of such an index returns 0x0000.
- R10: While the link level is steady, index 5 keeps any value written to it. The link rule acts only on a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Current link level (1 = up) |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| reg_idx | input | 5 | Register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |

## Verification
The bench targets four corner cases:
- Writes that land in the same cycle as a link edge. A design that gives the host write priority would lose the partner ability bits. One that drops the write would keep the stale value.
- The soft reset. A design that stores the written control value, or that skips reapplying the link level, reads back the wrong control or status value.
- Indices 16 and above. A design that truncates the index would corrupt the register that shares its low four bits, or would return data for an index that does not exist.
- A read and a write in the same cycle. A design that forwards the write would return the new value instead of the old one.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DATA_W    = 16;
    localparam int REG_COUNT = 16;
    localparam int IDX_W     = 5;
    localparam int SEL_W     = $clog2(REG_COUNT);

    typedef logic [DATA_W-1:0] word_t;

    // Register positions that the behaviour depends on
    localparam int IX_CTRL  = 0;
    localparam int IX_STAT  = 1;
    localparam int IX_ID_HI = 2;
    localparam int IX_ID_LO = 3;
    localparam int IX_ADV   = 4;
    localparam int IX_PEER  = 5;

    localparam int    SOFT_RST_BIT = 15;
    localparam int    LINK_BIT     = 2;
    localparam word_t PEER_UP_OR   = 16'h01E1;
    localparam word_t PEER_DN_AND  = 16'h01FF;

    typedef enum logic [1:0] {
        WR_IGNORE = 2'd0,
        WR_STORE  = 2'd1,
        WR_RELOAD = 2'd2
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e             kind;
        logic [REG_COUNT-1:0] sel;
    } wr_cmd_t;

    function automatic word_t boot_value(input int unsigned ix);
        case (ix)
            IX_CTRL:  return 16'h1000;
            IX_STAT:  return 16'h7848;
            IX_ID_HI: return 16'h2000;
            IX_ID_LO: return 16'h5C90;
            IX_ADV:   return 16'h01E1;
            default:  return '0;
        endcase
    endfunction

    function automatic logic is_read_only(input int unsigned ix);
        return (ix == IX_STAT) || (ix == IX_ID_HI) || (ix == IX_ID_LO);
    endfunction

    function automatic word_t link_overlay(input int unsigned ix, input word_t v,
                                           input logic up);
        word_t r;
        r = v;
        if (ix == IX_STAT) begin
            r[LINK_BIT] = up;
        end else if (ix == IX_PEER) begin
            r = up ? (v | PEER_UP_OR) : (v & PEER_DN_AND);
        end
        return r;
    endfunction

    function automatic word_t next_word(input int unsigned ix, input word_t cur,
                                        input word_t wdat, input logic reload,
                                        input logic store, input logic chg,
                                        input logic up);
        word_t n;
        if (reload) begin
            n = link_overlay(ix, boot_value(ix), up);
        end else begin
            n = store ? wdat : cur;
            if (chg) begin
                n = link_overlay(ix, n, up);
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/phy_mgmt_wr_decode.sv
module phy_mgmt_wr_decode
    import phy_mgmt_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    parameter int IW   = IDX_W,
    parameter int DW   = DATA_W
) (
    input  logic          wr_en,
    input  logic [IW-1:0] reg_idx,
    input  logic [DW-1:0] wr_data,
    output wr_cmd_t       cmd
);
    localparam int SW = $clog2(NREG);

    logic in_range;
    assign in_range = (reg_idx[IW-1:SW] == '0);

    always_comb begin
        cmd.kind = WR_IGNORE;
        cmd.sel  = '0;
        if (wr_en && in_range) begin
            cmd.sel[reg_idx[SW-1:0]] = 1'b1;
            if (int'(reg_idx[SW-1:0]) == IX_CTRL && wr_data[SOFT_RST_BIT]) begin
                cmd.kind = WR_RELOAD;
            end else if (!is_read_only(int'(reg_idx[SW-1:0]))) begin
                cmd.kind = WR_STORE;
            end
        end
    end
endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank
    import phy_mgmt_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    parameter int DW   = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   link_up,
    input  wr_cmd_t                cmd,
    input  logic [DW-1:0]          wr_data,
    output logic [NREG-1:0][DW-1:0] bank_q
);
    logic                    link_q;
    logic                    link_chg;
    logic                    reload;
    logic [NREG-1:0][DW-1:0] bank_d;

    assign link_chg = (link_up != link_q);
    assign reload   = rst || (cmd.kind == WR_RELOAD);

    for (genvar g = 0; g < NREG; g++) begin : g_word
        assign bank_d[g] = next_word(g, bank_q[g], wr_data, reload,
                                     (cmd.kind == WR_STORE) && cmd.sel[g],
                                     link_chg, link_up);
    end

    always_ff @(posedge clk) begin
        link_q <= link_up;
        bank_q <= bank_d;
    end
endmodule

// File: rtl/phy_mgmt_rd_port.sv
module phy_mgmt_rd_port
    import phy_mgmt_pkg::*;
#(
    parameter int NREG = REG_COUNT,
    parameter int IW   = IDX_W,
    parameter int DW   = DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [IW-1:0]           reg_idx,
    input  logic [NREG-1:0][DW-1:0] bank_q,
    output logic [DW-1:0]           rd_data
);
    localparam int SW = $clog2(NREG);

    logic [DW-1:0] pick;

    always_comb begin
        pick = '0;
        if (reg_idx[IW-1:SW] == '0) begin
            pick = bank_q[reg_idx[SW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= pick;
        end
    end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_up,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    wr_cmd_t                         cmd;
    logic [REG_COUNT-1:0][DATA_W-1:0] bank_q;

    phy_mgmt_wr_decode u_dec (
        .wr_en   (wr_en),
        .reg_idx (reg_idx),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    phy_mgmt_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .cmd     (cmd),
        .wr_data (wr_data),
        .bank_q  (bank_q)
    );

    phy_mgmt_rd_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .reg_idx (reg_idx),
        .bank_q  (bank_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker
    import phy_mgmt_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            link_up,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [IDX_W-1:0]                reg_idx,
    input logic [DATA_W-1:0]               wr_data,
    input logic [DATA_W-1:0]               rd_data,
    input logic [REG_COUNT-1:0][DATA_W-1:0] bank
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_far_index_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_idx >= IDX_W'(REG_COUNT)) |=> (rd_data == '0));

    assert_id_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_idx == IDX_W'(IX_ID_HI)) |=> (rd_data == 16'h2000));

    assert_soft_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_idx == IDX_W'(IX_CTRL) && wr_data[SOFT_RST_BIT])
        |=> (bank[IX_CTRL] == 16'h1000));

    assert_link_set_R6: assert property (@(posedge clk) disable iff (rst)
        link_up |=> bank[IX_STAT][LINK_BIT]);

    assert_link_clr_R7: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !bank[IX_STAT][LINK_BIT]);
endmodule

bind phy_mgmt_regs phy_mgmt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .reg_idx (reg_idx),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .bank    (bank_q)
);

// File: tb/phy_mgmt_regs_test.sv
`timescale 1ns/1ps
module phy_mgmt_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit pend = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    phy_mgmt_regs uut (
        .clk(clk), .rst(rst), .link_up(link_up), .wr_en(wr_en), .rd_en(rd_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one-cycle drive; a read pushes its expected value
    task automatic cyc(input logic w, input logic r, input logic [4:0] ix,
                       input logic [15:0] d, input logic [15:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = w; rd_en = r; reg_idx = ix; wr_data = d;
        if (r) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; reg_idx = '0; wr_data = '0;
    endtask

    task automatic rd(input logic [4:0] ix, input logic [15:0] exp, input string tag);
        cyc(0, 1, ix, '0, exp, tag);
    endtask

    task automatic wr(input logic [4:0] ix, input logic [15:0] d);
        cyc(1, 0, ix, d, '0, "");
    endtask

    // monitor: compares one cycle after a read strobe
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check(rd_data, 16'hxxxx, "scoreboard underflow");
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
        pend = rd_en && !rst;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(rd_data, 16'h0000, "R1 rd_data at reset");
        // R1 reset values, link down
        rd(0, 16'h1000, "R1 ctrl");
        rd(1, 16'h7848, "R1 status");
        rd(2, 16'h2000, "R1 id hi");
        rd(3, 16'h5C90, "R1 id lo");
        rd(4, 16'h01E1, "R1 adv");
        rd(5, 16'h0000, "R1 peer");
        rd(9, 16'h0000, "R1 other");
        // R3 stores
        wr(4, 16'h1234);
        wr(15, 16'hBEEF);
        rd(4, 16'h1234, "R3 idx4");
        rd(15, 16'hBEEF, "R3 idx15");
        // R4 read-only
        wr(1, 16'hFFFF);
        wr(2, 16'h0000);
        wr(3, 16'h0000);
        rd(1, 16'h7848, "R4 status");
        rd(2, 16'h2000, "R4 id hi");
        rd(3, 16'h5C90, "R4 id lo");
        // R5 plain control store
        wr(0, 16'h0100);
        rd(0, 16'h0100, "R5 ctrl store");
        // R6 link up
        idle(); link_up = 1;
        idle();
        rd(1, 16'h784C, "R6 status bit2");
        rd(5, 16'h01E1, "R6 peer or");
        // R10 steady link keeps written peer value
        wr(5, 16'h0000);
        rd(5, 16'h0000, "R10 peer kept");
        // R7 link down masks
        wr(5, 16'hFFFF);
        idle(); link_up = 0;
        idle();
        rd(1, 16'h7848, "R7 status bit2");
        rd(5, 16'h01FF, "R7 peer mask");
        // R8 write during link change
        wr(5, 16'h8000); link_up = 1;
        rd(5, 16'h81E1, "R8 peer write+up");
        wr(6, 16'h5555); link_up = 0;
        rd(6, 16'h5555, "R8 other write");
        rd(1, 16'h7848, "R8 status down");
        // R9 far index
        wr(20, 16'hAAAA);
        rd(4, 16'h1234, "R9 alias untouched");
        rd(20, 16'h0000, "R9 far read");
        // R2 read-before-write and hold
        wr(7, 16'h1111);
        cyc(1, 1, 7, 16'h2222, 16'h1111, "R2 old value");
        rd(7, 16'h2222, "R2 new value");
        idle();
        repeat (3) @(negedge clk);
        check(rd_data, 16'h2222, "R2 hold");
        // R5 soft reset with link up
        link_up = 1;
        idle();
        wr(0, 16'h8000);
        rd(0, 16'h1000, "R5 ctrl reload");
        rd(4, 16'h01E1, "R5 adv reload");
        rd(15, 16'h0000, "R5 idx15 cleared");
        rd(1, 16'h784C, "R5 status link");
        rd(5, 16'h01E1, "R5 peer link");
        idle();
        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) check(16'(exp_q.size()), 16'h0, "scoreboard drain");
        done = 1;
        summary();
    end
endmodule